// File: doc/BRIEF.md
# Up-Counting Timer with Buffered Prescaler

This block is a general-purpose up-counter with a clock divider in front of it, configured and observed through a simple single-cycle register write/read port. The divider produces one counting tick every PSC+1 clock cycles. The counter advances on each tick and wraps to zero once it has reached the reload limit. Each wrap is an update event and sets a sticky flag. The flag, gated by an enable bit, drives a level interrupt line.

The divider setting is double-buffered. Software writes the divider value into a holding register. The live divider picks that value up only on an update event, which is either a counter wrap or a software-forced update. After reset the live divider is zero, so the first period runs undivided unless software forces an update. To start cleanly, software writes the divider, forces an update, clears the flag, then sets the limit and starts counting. The reload limit is not buffered and acts at once.

Register word addresses: 0 control (bit 0 run), 1 interrupt enable (bit 0), 2 status (bit 0 update flag), 3 event trigger (bit 0 force update), 4 divider holding value, 5 reload limit. Reads of other addresses return zero.

Top module: `tick_timer`

## Requirements
- R1: After reset, every register at addresses 0 to 5 reads zero, `irq_o` is low and the live divider is zero, so the first period after reset runs at one tick per clock.
- R2: The counter and the divider phase advance only while control bit 0 (address 0) is 1. While it is 0, no wrap occurs.
- R3: The counter advances once every PSC+1 clocks. It wraps to zero on the tick on which it is at or above the reload limit, so one period lasts (PSC+1)*(LIMIT+1) clocks. Each wrap sets status bit 0 (address 2).
- R4: A value written to address 4 reads back at once. It reaches the live divider only at the next update event.
- R5: Writing 1 to bit 0 of address 3 produces an update event in the write cycle. The event loads the divider, sets status bit 0, and zeroes both the counter and the divider phase. Address 3 always reads zero.
- R6: Writing 0 to status bit 0 clears it. Writing 1 leaves it unchanged.
- R7: When an update event and a clearing write to the status register fall in the same cycle, the flag ends up set.
- R8: `irq_o` is a registered level equal to status bit 0 AND interrupt-enable bit 0 (address 1). It changes on the same clock edge as those bits.
- R9: A write to address 5 takes effect on the next tick, without waiting for an update event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously to clk_i |
| wr_en_i | input | 1 | Write strobe, one write per asserted cycle |
| addr_i | input | 3 | Register word address |
| wr_data_i | input | DW | Write data |
| rd_data_o | output | DW | Read data for addr_i (combinational) |
| irq_o | output | 1 | Update interrupt level |

## Verification
The hardest case to reach from the ports is a wrap that lands in the same cycle as a software write that clears the flag. A free-running timer rarely lines the two up. The stimulus forces both the divider and the limit to zero and starts the counter, so that a wrap happens on every clock. Any clear written then is guaranteed to collide with a hardware set, and the flag must read back as set. The buffered-divider hazard is covered by starting without a forced update and measuring the short first period against the longer second one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int TMR_AW = 3;

  typedef enum logic [TMR_AW-1:0] {
    RA_CTRL  = 3'd0,
    RA_IEN   = 3'd1,
    RA_STAT  = 3'd2,
    RA_EVGEN = 3'd3,
    RA_DIV   = 3'd4,
    RA_LIMIT = 3'd5
  } tmr_addr_e;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [TMR_AW-1:0] addr_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic [DW-1:0]     rd_data_o,
  input  logic              uev_i,
  output logic              run_o,
  output logic              ug_o,
  output logic [DW-1:0]     div_pre_o,
  output logic [DW-1:0]     limit_o,
  output logic              irq_o
);
  localparam logic [DW-1:0] ZERO = '0;

  logic sel_ctrl, sel_ien, sel_stat, sel_evg, sel_div, sel_lim;
  logic run_q, run_d, ien_q, ien_d, flag_q, flag_d, irq_q, irq_d;
  logic [DW-1:0] div_q, lim_q;

  always_comb begin
    sel_ctrl = wr_en_i && (addr_i == RA_CTRL);
    sel_ien  = wr_en_i && (addr_i == RA_IEN);
    sel_stat = wr_en_i && (addr_i == RA_STAT);
    sel_evg  = wr_en_i && (addr_i == RA_EVGEN);
    sel_div  = wr_en_i && (addr_i == RA_DIV);
    sel_lim  = wr_en_i && (addr_i == RA_LIMIT);

    run_d = sel_ctrl ? wr_data_i[0] : run_q;
    ien_d = sel_ien  ? wr_data_i[0] : ien_q;

    // hardware set has priority over a bus clear in the same cycle
    if (uev_i)         flag_d = 1'b1;
    else if (sel_stat) flag_d = flag_q & wr_data_i[0];
    else               flag_d = flag_q;

    irq_d = flag_d & ien_d;
    ug_o  = sel_evg & wr_data_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      ien_q  <= 1'b0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      ien_q  <= ien_d;
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else if (sel_div) begin
      div_q <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q <= '0;
    end else if (sel_lim) begin
      lim_q <= wr_data_i;
    end
  end

  always_comb begin
    case (addr_i)
      RA_CTRL:  rd_data_o = {ZERO[DW-1:1], run_q};
      RA_IEN:   rd_data_o = {ZERO[DW-1:1], ien_q};
      RA_STAT:  rd_data_o = {ZERO[DW-1:1], flag_q};
      RA_DIV:   rd_data_o = div_q;
      RA_LIMIT: rd_data_o = lim_q;
      default:  rd_data_o = ZERO;
    endcase
  end

  assign run_o     = run_q;
  assign div_pre_o = div_q;
  assign limit_o   = lim_q;
  assign irq_o     = irq_q;

  // R7: an update event always leaves the flag set
  assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uev_i |=> flag_q);
  // R6: writing one to a set flag keeps it set
  assert_w1_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_stat && wr_data_i[0] && flag_q) |=> flag_q);
  // R6: a clear with no event leaves the flag low
  assert_w0_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_stat && !wr_data_i[0] && !uev_i) |=> !flag_q);
  // R8: interrupt level follows flag and enable
  assert_irq_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q == (flag_q && ien_q));
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          ug_i,
  input  logic          uev_i,
  input  logic [DW-1:0] div_pre_i,
  output logic          tick_o
);
  logic [DW-1:0] act_q, act_d, phase_q, phase_d;
  logic          phase_en, act_en, last;

  always_comb begin
    last     = (phase_q >= act_q);
    tick_o   = run_i && !ug_i && last;
    phase_en = ug_i || run_i;
    if (ug_i)      phase_d = '0;
    else if (last) phase_d = '0;
    else           phase_d = phase_q + 1'b1;
    act_en = uev_i;
    act_d  = div_pre_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
    end else if (phase_en) begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
    end else if (act_en) begin
      act_q <= act_d;
    end
  end

  // R4: the live divider moves only on an update event
  assert_div_shadow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uev_i |=> $stable(act_q));
  // R2: the phase holds while stopped and not forced
  assert_phase_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !ug_i) |=> $stable(phase_q));
  // R5: a forced update restarts the phase
  assert_phase_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ug_i |=> (phase_q == '0));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          ug_i,
  input  logic [DW-1:0] limit_i,
  output logic          wrap_o
);
  logic [DW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    wrap_o = tick_i && (cnt_q >= limit_i);
    cnt_en = ug_i || tick_i;
    if (ug_i || wrap_o) cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R3: a wrap returns the count to zero
  assert_wrap_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));
  // R2: without a tick or forced update the count holds
  assert_cnt_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !ug_i) |=> $stable(cnt_q));
  // R3: a tick below the limit adds exactly one
  assert_cnt_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !ug_i && (cnt_q < limit_i)) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tmr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [TMR_AW-1:0] addr_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic [DW-1:0]     rd_data_o,
  output logic              irq_o
);
  logic          run, ug, tick, wrap, uev;
  logic [DW-1:0] div_pre, limit;

  assign uev = wrap | ug;

  tmr_regs #(.DW(DW)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .uev_i     (uev),
    .run_o     (run),
    .ug_o      (ug),
    .div_pre_o (div_pre),
    .limit_o   (limit),
    .irq_o     (irq_o)
  );

  tmr_prescaler #(.DW(DW)) i_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .ug_i      (ug),
    .uev_i     (uev),
    .div_pre_i (div_pre),
    .tick_o    (tick)
  );

  tmr_counter #(.DW(DW)) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .ug_i    (ug),
    .limit_i (limit),
    .wrap_o  (wrap)
  );

  // R2: no tick while stopped
  assert_no_tick_stopped_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> !tick);
  // R5: the event register never reads back a one
  assert_evgen_reads0_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == RA_EVGEN) |-> (rd_data_o == '0));
endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;
  localparam int DW = 16;
  localparam int NV = 7;
  localparam int VEC_DIV [NV] = '{0, 0, 3, 2, 1, 15999, 4};
  localparam int VEC_LIM [NV] = '{0, 5, 4, 0, 7, 0,     9};
  localparam int VEC_PER [NV] = '{1, 6, 20, 3, 16, 16000, 50};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [2:0]    addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tick_timer #(.DW(DW)) i_tick_timer (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .addr_i    (addr),
    .wr_data_i (wdata),
    .rd_data_o (rdata),
    .irq_o     (irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    addr  = a;
    wdata = DW'(d);
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    addr = a;
    #1;
    d = int'(rdata);
  endtask

  task automatic measure(output int n);
    n = 0;
    while (!irq && n < 100000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // stop, load divider through a forced update, clear flag, set limit
  task automatic prog(input int dv, input int lim);
    wr(3'd0, 0);
    wr(3'd4, dv);
    wr(3'd3, 1);
    wr(3'd2, 0);
    wr(3'd5, lim);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int v, n;
    rst_n = 1'b0;
    wr_en = 1'b0;
    addr  = '0;
    wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1 reset read", v, 0);
    end
    chk("R1 irq after reset", int'(irq), 0);

    // R4 / R1: divider written but not forced; first period undivided
    wr(3'd4, 9);
    rd(3'd4, v);
    chk("R4 divider readback", v, 9);
    wr(3'd5, 2);
    wr(3'd1, 1);
    wr(3'd0, 1);
    measure(n);
    chk("R1 first period undivided", n, 3);
    wr(3'd2, 0);
    measure(n);
    // clear write consumed one clock of the 30-clock second period
    chk("R4 divider applied after wrap", n, 29);

    // R3 / R9: vector table of divider, limit, expected period
    for (int i = 0; i < NV; i++) begin
      prog(VEC_DIV[i], VEC_LIM[i]);
      wr(3'd0, 1);
      measure(n);
      chk("R3 R9 period", n, VEC_PER[i]);
    end

    // R5: forced update sets flag, event register reads zero
    wr(3'd0, 0);
    wr(3'd1, 0);
    wr(3'd2, 0);
    wr(3'd3, 1);
    rd(3'd2, v);
    chk("R5 forced update sets flag", v, 1);
    rd(3'd3, v);
    chk("R5 event reg reads zero", v, 0);

    // R8: gate by enable
    chk("R8 irq low while disabled", int'(irq), 0);
    wr(3'd1, 1);
    chk("R8 irq high once enabled", int'(irq), 1);

    // R6: write one keeps, write zero clears, write one on clear stays clear
    wr(3'd2, 1);
    rd(3'd2, v);
    chk("R6 write one keeps flag", v, 1);
    wr(3'd2, 0);
    rd(3'd2, v);
    chk("R6 write zero clears flag", v, 0);
    chk("R8 irq follows cleared flag", int'(irq), 0);
    wr(3'd2, 1);
    rd(3'd2, v);
    chk("R6 write one does not set", v, 0);

    // R2: stopped timer with limit 0 never wraps
    prog(0, 0);
    repeat (40) @(negedge clk);
    rd(3'd2, v);
    chk("R2 no wrap while stopped", v, 0);
    chk("R2 irq low while stopped", int'(irq), 0);

    // R7: wrap every clock collides with clear
    wr(3'd0, 1);
    wr(3'd2, 0);
    rd(3'd2, v);
    chk("R7 set wins over clear", v, 1);
    wr(3'd0, 0);
    wr(3'd2, 0);
    rd(3'd2, v);
    chk("R7 clear once stopped", v, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule